// File: doc/BRIEF.md
# Multi-Level Standby Mode Controller

This block sequences a processor through three low-power tiers and back to normal execution. The CPU asks for a tier through a 2-bit mode request. The controller then drives clock-gating enables for the CPU core, the general peripheral group, a base timer and an infrared receiver. It also drives run enables for four oscillators: a PLL, a ceramic resonator, an RC oscillator and a crystal. The low-speed RC oscillator is owned by the watchdog. The controller passes the watchdog's enable for it through, except in one case where it freezes that enable.

The light tier (halt) stops only the CPU clock. The deep tier (hold) stops every clock and every oscillator. The crystal-retaining tier (crystal-hold) stops the PLL, ceramic and RC oscillators and leaves the crystal as it was. In crystal-hold the base timer and the infrared receiver keep running.

Each tier has its own set of wake sources. A reset-class event (reset pin low, watchdog reset or low-voltage reset) returns the block to run at once and raises a one-cycle system-reset pulse. An interrupt-class wake from a deep tier does not go straight to run. It first restores the oscillators that were running at entry, then waits a stabilization interval, and only then opens the CPU and peripheral clocks.

Top module: `stby_ctrl`

## Requirements
- R1: Synchronous reset `rst` sets all four clock enables to 1, `osc_en_o` to 0, `lrc_en_o` to 0 and the reset pulse to 0. In run and halt, `osc_en_o` equals `osc_cfg_i` delayed by one cycle (bit 0 PLL, bit 1 ceramic, bit 2 RC, bit 3 crystal).
- R2: A request is sampled when `req_valid_i` is 1. `req_mode_i` encodes 00 run (no change), 01 halt, 10 hold and 11 crystal-hold. An accepted request changes the outputs on the same clock edge that samples it.
- R3: A request made in any state other than run is ignored, and the outputs stay unchanged.
- R4: In halt, the CPU clock enable is 0. The peripheral, base-timer and infrared enables are 1, and no oscillator is stopped.
- R5: Halt returns to run on the edge that samples `irq_any_i` = 1, with no reset pulse.
- R6: In hold, all four clock enables and all of `osc_en_o` are 0.
- R7: Hold wakes on `ext_irq_i` bits 2..4 (external lines 2, 4 and 5), on `port0_irq_i` or on `usb_irq_i`. `irq_any_i`, `btmr_irq_i` and `ir_irq_i` have no effect on hold.
- R8: `ext_irq_i` bits 0 and 1 (external lines 0 and 1) wake either deep tier only while the matching `ext_lvl_i` bit is 1 (level-sensitive). While that bit is 0, the line is ignored.
- R9: In crystal-hold, the CPU and peripheral enables are 0 and the base-timer and infrared enables are 1. `osc_en_o` bits 0..2 are 0, and bit 3 holds the `osc_cfg_i[3]` value sampled at entry, whatever `osc_cfg_i` does later.
- R10: Crystal-hold wakes on every hold source and also on `btmr_irq_i` or `ir_irq_i`.
- R11: `lrc_en_o` follows `lrc_wdt_en_i` with one cycle of delay. The exception is crystal-hold entered while `btmr_lrc_sel_i` was 1: there `lrc_en_o` keeps the value of `lrc_wdt_en_i` sampled at entry.
- R12: An interrupt wake from a deep tier sets `osc_en_o` to the `osc_cfg_i` value sampled at entry, on the waking edge. The CPU and peripheral enables then stay 0 for STAB_CYCLES cycles (default 16) before rising. The base-timer and infrared enables stay 1 during this interval only when the wake came from crystal-hold. No reset pulse is produced.
- R13: A reset-class event (`rst_pin_n_i` = 0, `wdt_rst_i` = 1 or `lvd_rst_i` = 1) in any state puts the outputs in the run state on the sampling edge. `sys_rst_pulse_o` is 1 for exactly one cycle at each onset of such an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 2 | Requested mode (00 run, 01 halt, 10 hold, 11 crystal-hold) |
| rst_pin_n_i | input | 1 | External reset pin, active low |
| wdt_rst_i | input | 1 | Watchdog reset request |
| lvd_rst_i | input | 1 | Low-voltage reset request |
| irq_any_i | input | 1 | Any pending interrupt (halt wake) |
| ext_irq_i | input | N_EXT (5) | External lines 0, 1, 2, 4, 5 on bits 0..4 |
| ext_lvl_i | input | N_LVL (2) | Level-sensitive flag for bits 0..1 of ext_irq_i |
| port0_irq_i | input | 1 | Port-0 interrupt |
| usb_irq_i | input | 1 | USB host bus-active interrupt |
| btmr_irq_i | input | 1 | Base-timer interrupt |
| ir_irq_i | input | 1 | Infrared-receiver interrupt |
| osc_cfg_i | input | 4 | Oscillators software wants running |
| lrc_wdt_en_i | input | 1 | Watchdog's low-speed RC enable |
| btmr_lrc_sel_i | input | 1 | Base timer is clocked from the low-speed RC |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | General peripheral clock enable |
| btmr_clk_en_o | output | 1 | Base-timer clock enable |
| ir_clk_en_o | output | 1 | Infrared-receiver clock enable |
| osc_en_o | output | 4 | Oscillator run enables |
| lrc_en_o | output | 1 | Low-speed RC enable |
| sys_rst_pulse_o | output | 1 | One-cycle system reset pulse |

## Verification
The hardest situation to reach from the ports is a reset-class event that arrives partway through the stabilization wait after a deep-tier interrupt wake. Reaching it needs a deep entry, a masked wake source and then a reset within a 16-cycle window. A directed sequence builds this exactly: it enters hold, wakes through port 0 and asserts a low-voltage reset three cycles later. A long seeded random phase with rare wake and reset pulses repeats similar overlaps, and a cycle-level model in the bench checks every output on every cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_HALT  = 3'd1,
    ST_HOLD  = 3'd2,
    ST_XHOLD = 3'd3,
    ST_STAB  = 3'd4
  } stby_st_e;

  localparam logic [1:0] REQ_RUN   = 2'b00;
  localparam logic [1:0] REQ_HALT  = 2'b01;
  localparam logic [1:0] REQ_HOLD  = 2'b10;
  localparam logic [1:0] REQ_XHOLD = 2'b11;

  localparam int NUM_OSC  = 4;
  localparam int OSC_PLL  = 0;
  localparam int OSC_CER  = 1;
  localparam int OSC_RC   = 2;
  localparam int OSC_XTAL = 3;

endpackage

// File: rtl/stby_wake.sv
module stby_wake #(
  parameter int N_EXT = 5,
  parameter int N_LVL = 2
) (
  input  logic             rst_pin_n,
  input  logic             wdt_rst,
  input  logic             lvd_rst,
  input  logic             irq_any,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_LVL-1:0] ext_lvl,
  input  logic             port0_irq,
  input  logic             usb_irq,
  input  logic             btmr_irq,
  input  logic             ir_irq,
  output logic             rst_evt,
  output logic             wake_halt,
  output logic             wake_hold,
  output logic             wake_xhold
);

  logic [N_EXT-1:0] ext_ok;

  // lines with a trigger-type flag only count when level-sensitive
  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    if (i < N_LVL) begin : g_gated
      assign ext_ok[i] = ext_irq[i] & ext_lvl[i];
    end else begin : g_plain
      assign ext_ok[i] = ext_irq[i];
    end
  end

  assign rst_evt    = ~rst_pin_n | wdt_rst | lvd_rst;
  assign wake_halt  = irq_any;
  assign wake_hold  = (|ext_ok) | port0_irq | usb_irq;
  assign wake_xhold = wake_hold | btmr_irq | ir_irq;

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     req_valid,
  input  logic [1:0] req_mode,
  input  logic     rst_evt,
  input  logic     wake_halt,
  input  logic     wake_hold,
  input  logic     wake_xhold,
  output stby_st_e st_q,
  output stby_st_e st_nxt,
  output logic     from_x_q
);

  localparam int CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_RUN: begin
        if (req_valid) begin
          unique case (req_mode)
            REQ_HALT:  st_nxt = ST_HALT;
            REQ_HOLD:  st_nxt = ST_HOLD;
            REQ_XHOLD: st_nxt = ST_XHOLD;
            default:   st_nxt = ST_RUN;
          endcase
        end
      end
      ST_HALT:  if (wake_halt)  st_nxt = ST_RUN;
      ST_HOLD:  if (wake_hold)  st_nxt = ST_STAB;
      ST_XHOLD: if (wake_xhold) st_nxt = ST_STAB;
      ST_STAB:  if (cnt_q == '0) st_nxt = ST_RUN;
      default:  st_nxt = ST_RUN;
    endcase
    if (rst_evt) st_nxt = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      cnt_q    <= '0;
      from_x_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (st_q != ST_STAB && st_nxt == ST_STAB) begin
        cnt_q <= CNT_LOAD;
      end else if (st_q == ST_STAB && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (st_q != ST_STAB) begin
        from_x_q <= (st_q == ST_XHOLD);
      end
    end
  end

  AST_NO_STANDBY_HOP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT || st_q == ST_HOLD || st_q == ST_XHOLD) |=>
    (st_q == $past(st_q) || st_q == ST_RUN || st_q == ST_STAB)); // R3

  AST_HALT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT && wake_halt) |=> (st_q == ST_RUN)); // R5

  AST_RST_FORCES_RUN: assert property (@(posedge clk) disable iff (rst)
    rst_evt |=> (st_q == ST_RUN)); // R13

  AST_STAB_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STAB) |-> (cnt_q <= CNT_LOAD)); // R12

endmodule

// File: rtl/stby_outreg.sv
module stby_outreg
  import stby_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  stby_st_e           st_q,
  input  stby_st_e           st_nxt,
  input  logic               from_x_q,
  input  logic               rst_evt,
  input  logic [NUM_OSC-1:0] osc_cfg,
  input  logic               lrc_wdt_en,
  input  logic               btmr_lrc_sel,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               btmr_clk_en,
  output logic               ir_clk_en,
  output logic [NUM_OSC-1:0] osc_en,
  output logic               lrc_en,
  output logic               sys_rst_pulse
);

  logic [NUM_OSC-1:0] snap_osc_q;
  logic               snap_lrc_q;
  logic               snap_frz_q;
  logic               rst_evt_q;
  logic               entering;
  logic               x_origin;
  logic               xtal_keep;
  logic               frz_now;
  logic               lrc_hold;
  logic [NUM_OSC-1:0] xhold_osc;

  assign entering  = (st_q == ST_RUN) &&
                     (st_nxt == ST_HOLD || st_nxt == ST_XHOLD);
  assign x_origin  = (st_q == ST_XHOLD) || (st_q == ST_STAB && from_x_q);
  assign xtal_keep = (st_q == ST_RUN) ? osc_cfg[OSC_XTAL] : snap_osc_q[OSC_XTAL];
  assign frz_now   = (st_q == ST_RUN) ? btmr_lrc_sel : snap_frz_q;
  assign lrc_hold  = (st_q == ST_RUN) ? lrc_wdt_en : snap_lrc_q;

  always_comb begin
    xhold_osc           = '0;
    xhold_osc[OSC_XTAL] = xtal_keep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_osc_q <= '0;
      snap_lrc_q <= 1'b0;
      snap_frz_q <= 1'b0;
    end else if (entering) begin
      snap_osc_q <= osc_cfg;
      snap_lrc_q <= lrc_wdt_en;
      snap_frz_q <= btmr_lrc_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en    <= 1'b1;
      per_clk_en    <= 1'b1;
      btmr_clk_en   <= 1'b1;
      ir_clk_en     <= 1'b1;
      osc_en        <= '0;
      lrc_en        <= 1'b0;
      rst_evt_q     <= 1'b0;
      sys_rst_pulse <= 1'b0;
    end else begin
      rst_evt_q     <= rst_evt;
      sys_rst_pulse <= rst_evt & ~rst_evt_q;
      lrc_en        <= (st_nxt == ST_XHOLD && frz_now) ? lrc_hold : lrc_wdt_en;
      unique case (st_nxt)
        ST_HALT: begin
          {cpu_clk_en, per_clk_en, btmr_clk_en, ir_clk_en} <= 4'b0111;
          osc_en <= osc_cfg;
        end
        ST_HOLD: begin
          {cpu_clk_en, per_clk_en, btmr_clk_en, ir_clk_en} <= 4'b0000;
          osc_en <= '0;
        end
        ST_XHOLD: begin
          {cpu_clk_en, per_clk_en, btmr_clk_en, ir_clk_en} <= 4'b0011;
          osc_en <= xhold_osc;
        end
        ST_STAB: begin
          {cpu_clk_en, per_clk_en, btmr_clk_en, ir_clk_en} <=
            {2'b00, x_origin, x_origin};
          osc_en <= snap_osc_q;
        end
        default: begin
          {cpu_clk_en, per_clk_en, btmr_clk_en, ir_clk_en} <= 4'b1111;
          osc_en <= osc_cfg;
        end
      endcase
    end
  end

  AST_HOLD_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD) |-> (osc_en == '0 && !cpu_clk_en && !per_clk_en)); // R6

  AST_XTAL_KEPT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XHOLD && $past(st_q) == ST_XHOLD) |-> $stable(osc_en[OSC_XTAL])); // R9

  AST_STAB_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STAB) |-> (!cpu_clk_en && !per_clk_en)); // R12

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_pulse |=> !sys_rst_pulse); // R13

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int STAB_CYCLES = 16,
  parameter int N_EXT       = 5,
  parameter int N_LVL       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid_i,
  input  logic [1:0]         req_mode_i,
  input  logic               rst_pin_n_i,
  input  logic               wdt_rst_i,
  input  logic               lvd_rst_i,
  input  logic               irq_any_i,
  input  logic [N_EXT-1:0]   ext_irq_i,
  input  logic [N_LVL-1:0]   ext_lvl_i,
  input  logic               port0_irq_i,
  input  logic               usb_irq_i,
  input  logic               btmr_irq_i,
  input  logic               ir_irq_i,
  input  logic [NUM_OSC-1:0] osc_cfg_i,
  input  logic               lrc_wdt_en_i,
  input  logic               btmr_lrc_sel_i,
  output logic               cpu_clk_en_o,
  output logic               per_clk_en_o,
  output logic               btmr_clk_en_o,
  output logic               ir_clk_en_o,
  output logic [NUM_OSC-1:0] osc_en_o,
  output logic               lrc_en_o,
  output logic               sys_rst_pulse_o
);

  logic     rst_evt;
  logic     wake_halt;
  logic     wake_hold;
  logic     wake_xhold;
  stby_st_e st_q;
  stby_st_e st_nxt;
  logic     from_x_q;

  stby_wake #(
    .N_EXT (N_EXT),
    .N_LVL (N_LVL)
  ) u_wake (
    .rst_pin_n  (rst_pin_n_i),
    .wdt_rst    (wdt_rst_i),
    .lvd_rst    (lvd_rst_i),
    .irq_any    (irq_any_i),
    .ext_irq    (ext_irq_i),
    .ext_lvl    (ext_lvl_i),
    .port0_irq  (port0_irq_i),
    .usb_irq    (usb_irq_i),
    .btmr_irq   (btmr_irq_i),
    .ir_irq     (ir_irq_i),
    .rst_evt    (rst_evt),
    .wake_halt  (wake_halt),
    .wake_hold  (wake_hold),
    .wake_xhold (wake_xhold)
  );

  stby_fsm #(
    .STAB_CYCLES (STAB_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid_i),
    .req_mode   (req_mode_i),
    .rst_evt    (rst_evt),
    .wake_halt  (wake_halt),
    .wake_hold  (wake_hold),
    .wake_xhold (wake_xhold),
    .st_q       (st_q),
    .st_nxt     (st_nxt),
    .from_x_q   (from_x_q)
  );

  stby_outreg u_out (
    .clk           (clk),
    .rst           (rst),
    .st_q          (st_q),
    .st_nxt        (st_nxt),
    .from_x_q      (from_x_q),
    .rst_evt       (rst_evt),
    .osc_cfg       (osc_cfg_i),
    .lrc_wdt_en    (lrc_wdt_en_i),
    .btmr_lrc_sel  (btmr_lrc_sel_i),
    .cpu_clk_en    (cpu_clk_en_o),
    .per_clk_en    (per_clk_en_o),
    .btmr_clk_en   (btmr_clk_en_o),
    .ir_clk_en     (ir_clk_en_o),
    .osc_en        (osc_en_o),
    .lrc_en        (lrc_en_o),
    .sys_rst_pulse (sys_rst_pulse_o)
  );

  AST_HALT_CPU_ONLY: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT) |-> (!cpu_clk_en_o && per_clk_en_o && btmr_clk_en_o)); // R4

  AST_XHOLD_TIMERS_ON: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XHOLD) |-> (btmr_clk_en_o && ir_clk_en_o && !per_clk_en_o
                            && osc_en_o[OSC_PLL] == 1'b0)); // R9

endmodule

// File: tb/stby_ctrl_tb.sv
module stby_ctrl_tb;

  localparam int STAB = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic       pin_n = 1'b1;
  logic       wdt = 1'b0;
  logic       lvd = 1'b0;
  logic       irq_any = 1'b0;
  logic [4:0] ext = '0;
  logic [1:0] lvl = '0;
  logic       p0 = 1'b0;
  logic       usb = 1'b0;
  logic       bt = 1'b0;
  logic       ir = 1'b0;
  logic [3:0] cfg = 4'hF;
  logic       lrc_wdt = 1'b1;
  logic       sel = 1'b0;

  logic       cpu_o, per_o, bt_o, ir_o, lrc_o, pls_o;
  logic [3:0] osc_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  stby_ctrl #(.STAB_CYCLES(STAB)) u_dut (
    .clk (clk), .rst (rst),
    .req_valid_i (req_valid), .req_mode_i (req_mode),
    .rst_pin_n_i (pin_n), .wdt_rst_i (wdt), .lvd_rst_i (lvd),
    .irq_any_i (irq_any), .ext_irq_i (ext), .ext_lvl_i (lvl),
    .port0_irq_i (p0), .usb_irq_i (usb), .btmr_irq_i (bt), .ir_irq_i (ir),
    .osc_cfg_i (cfg), .lrc_wdt_en_i (lrc_wdt), .btmr_lrc_sel_i (sel),
    .cpu_clk_en_o (cpu_o), .per_clk_en_o (per_o), .btmr_clk_en_o (bt_o),
    .ir_clk_en_o (ir_o), .osc_en_o (osc_o), .lrc_en_o (lrc_o),
    .sys_rst_pulse_o (pls_o)
  );

  // cycle model built from the requirements: 0 run 1 halt 2 hold 3 xhold 4 stab
  int         m_st = 0;
  int         m_cnt = 0;
  logic       m_rq = 1'b0;
  logic       m_fx = 1'b0;
  logic [3:0] m_snap_osc = '0;
  logic       m_snap_lrc = 1'b0;
  logic       m_frz = 1'b0;
  logic [3:0] e_clk = 4'b1111;
  logic [3:0] e_osc = '0;
  logic       e_lrc = 1'b0;
  logic       e_pls = 1'b0;

  always @(posedge clk) begin
    logic rev, whold, wx;
    logic [4:0] ok;
    int prev, n;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_rq = 1'b0; m_fx = 1'b0;
      m_snap_osc = '0; m_snap_lrc = 1'b0; m_frz = 1'b0;
      e_clk = 4'b1111; e_osc = '0; e_lrc = 1'b0; e_pls = 1'b0;
    end else begin
      rev   = !pin_n || wdt || lvd;
      ok    = {ext[4], ext[3], ext[2], ext[1] & lvl[1], ext[0] & lvl[0]};
      whold = (|ok) || p0 || usb;
      wx    = whold || bt || ir;
      prev  = m_st;
      n     = prev;
      case (prev)
        0: if (req_valid && req_mode != 2'b00) n = int'(req_mode);
        1: if (irq_any) n = 0;
        2: if (whold) n = 4;
        3: if (wx) n = 4;
        default: if (m_cnt == 0) n = 0;
      endcase
      if (rev) n = 0;
      if (prev != 4 && n == 4) m_cnt = STAB - 1;
      else if (prev == 4 && m_cnt != 0) m_cnt = m_cnt - 1;
      if (prev == 0 && (n == 2 || n == 3)) begin
        m_snap_osc = cfg; m_snap_lrc = lrc_wdt; m_frz = sel;
      end
      if (prev != 4) m_fx = (prev == 3);
      case (n)
        0: begin e_clk = 4'b1111; e_osc = cfg; end
        1: begin e_clk = 4'b0111; e_osc = cfg; end
        2: begin e_clk = 4'b0000; e_osc = 4'b0000; end
        3: begin e_clk = 4'b0011; e_osc = {m_snap_osc[3], 3'b000}; end
        default: begin e_clk = {2'b00, m_fx, m_fx}; e_osc = m_snap_osc; end
      endcase
      e_lrc = (n == 3 && m_frz) ? m_snap_lrc : lrc_wdt;
      e_pls = rev && !m_rq;
      m_rq  = rev;
      m_st  = n;
    end
  end

  function automatic string tag_of(int st, logic p);
    if (p) return "R13 reset wake";
    case (st)
      0: return "R2 run";
      1: return "R4 halt";
      2: return "R6 hold";
      3: return "R9 xhold";
      default: return "R12 stab";
    endcase
  endfunction

  task automatic chk(input logic [9:0] got, input logic [9:0] exp, input string msg);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at t=%0t", msg, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk({cpu_o, per_o, bt_o, ir_o, osc_o, lrc_o, pls_o},
        {e_clk, e_osc, e_lrc, e_pls}, tag_of(m_st, e_pls));
  endtask

  task automatic steps(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic request(input logic [1:0] md);
    req_valid = 1'b1; req_mode = md;
    step();
    req_valid = 1'b0; req_mode = 2'b00;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h51a7_0c3d));
    steps(3);
    chk({cpu_o, per_o, bt_o, ir_o, osc_o, lrc_o, pls_o}, 10'b1111_0000_00, "R1 reset state");
    rst = 1'b0;
    step();
    chk({6'd0, osc_o}, {6'd0, 4'hF}, "R1 osc follows cfg");

    request(2'b00);
    chk({6'd0, cpu_o, per_o, bt_o, ir_o}, 10'b1111, "R2 mode 00 no change");
    request(2'b01);
    chk({2'd0, cpu_o, per_o, bt_o, ir_o, osc_o}, {2'd0, 4'b0111, 4'hF}, "R4 halt enables");
    request(2'b10);
    chk({6'd0, cpu_o, per_o, bt_o, ir_o}, 10'b0111, "R3 request in halt ignored");
    irq_any = 1'b1; step(); irq_any = 1'b0;
    chk({8'd0, cpu_o, pls_o}, 10'b10, "R5 halt exit on interrupt");

    request(2'b10);
    chk({2'd0, cpu_o, per_o, bt_o, ir_o, osc_o}, 10'd0, "R6 hold all off");
    irq_any = 1'b1; bt = 1'b1; ir = 1'b1; ext = 5'b00011; lvl = 2'b00;
    steps(2);
    chk({2'd0, cpu_o, per_o, bt_o, ir_o, osc_o}, 10'd0, "R7 R8 hold ignores non-mask sources");
    lvl = 2'b01; step();
    irq_any = 1'b0; bt = 1'b0; ir = 1'b0; ext = '0; lvl = '0;
    chk({5'd0, cpu_o, osc_o}, {5'd0, 1'b0, 4'hF}, "R8 level line wakes, R12 osc restored");
    steps(STAB - 1);
    chk({9'd0, cpu_o}, 10'd0, "R12 cpu gated during stabilization");
    step();
    chk({8'd0, cpu_o, pls_o}, 10'b10, "R12 cpu ungated after count");

    cfg = 4'b0111; sel = 1'b1; lrc_wdt = 1'b1;
    request(2'b11);
    chk({2'd0, cpu_o, per_o, bt_o, ir_o, osc_o}, {2'd0, 4'b0011, 4'b0000}, "R9 xhold enables");
    cfg = 4'hF; lrc_wdt = 1'b0; step();
    chk({5'd0, osc_o, lrc_o}, {5'd0, 4'b0000, 1'b1}, "R9 R11 xtal and lrc frozen");
    bt = 1'b1; step(); bt = 1'b0;
    chk({4'd0, cpu_o, bt_o, osc_o}, {4'd0, 2'b01, 4'b0111}, "R10 base timer wakes xhold");
    steps(STAB);
    chk({4'd0, cpu_o, osc_o, lrc_o}, {4'd0, 1'b1, 4'hF, 1'b0}, "R11 lrc follows watchdog in run");
    sel = 1'b0;

    request(2'b10);
    wdt = 1'b1; step();
    chk({8'd0, cpu_o, pls_o}, 10'b11, "R13 watchdog wakes hold with pulse");
    step(); wdt = 1'b0;
    chk({9'd0, pls_o}, 10'd0, "R13 pulse lasts one cycle");

    request(2'b10);
    p0 = 1'b1; step(); p0 = 1'b0;
    steps(3);
    lvd = 1'b1; step(); lvd = 1'b0;
    chk({8'd0, cpu_o, pls_o}, 10'b11, "R13 reset during stabilization");
    usb = 1'b1; request(2'b11); usb = 1'b0;
    step();

    for (int i = 0; i < 30000; i++) begin
      req_valid = ($urandom_range(7) == 0);
      req_mode  = 2'($urandom_range(3));
      pin_n     = ($urandom_range(499) != 0);
      wdt       = ($urandom_range(599) == 0);
      lvd       = ($urandom_range(699) == 0);
      irq_any   = ($urandom_range(24) == 0);
      ext       = 5'($urandom_range(31)) & {5{$urandom_range(29) == 0}};
      if ($urandom_range(49) == 0) lvl = 2'($urandom_range(3));
      p0        = ($urandom_range(79) == 0);
      usb       = ($urandom_range(89) == 0);
      bt        = ($urandom_range(59) == 0);
      ir        = ($urandom_range(69) == 0);
      if ($urandom_range(19) == 0) cfg = 4'($urandom_range(15));
      if ($urandom_range(15) == 0) lrc_wdt = ~lrc_wdt;
      if ($urandom_range(31) == 0) sel = ~sel;
      step();
    end
    finish_run();
  end

endmodule